// File: doc/BRIEF.md
# Tagged Pair Store Execution Unit

This unit executes one instruction that stores a pair of 64-bit registers together with a 4-bit allocation tag for a 16-byte granule. It takes a 32-bit instruction word on a start pulse. It reads the base register and the two data registers through combinational register-file read ports, and it forms the access address in one of three index modes. It checks the stack-pointer and granule alignment. When the checks pass, it issues three write requests over a valid/ready handshake: first data word, second data word, then tag. Last, it writes the updated base back when the mode needs it.

The tag is not taken from the data registers. It comes from the logical tag field held in bits [59:56] of the access address. No tag comparison is made and no condition flags exist in the unit. A base field of 31 selects the stack pointer, which has its own read input and write port. A data field of 31 reads as zero.

The controller has eight named states:
- IDLE waits for start.
- READ latches the operands and decides between fault and store.
- WR_D1, WR_D2 and WR_TAG each hold one request until it is accepted.
- WBACK writes the new base.
- DONE pulses done for one cycle.
- FAULT pulses fault with a kind code for one cycle.

The transitions are:
- IDLE→READ on start.
- READ→FAULT on any check failure, otherwise READ→WR_D1.
- WR_D1→WR_D2 and WR_D2→WR_TAG on ready.
- WR_TAG→WBACK on ready with writeback, or WR_TAG→DONE on ready without writeback.
- WBACK→DONE.
- DONE→IDLE and FAULT→IDLE.

Top module: `tagpair_store_unit`

## Requirements
- R1: An instruction is legal only when bits [31:30]=01, [29:27]=101, bit 26=0, bit 22=0 and mode bits [25:23] are 001, 010 or 011. Any other word ends in a fault with fault_kind=3, with no write request and no writeback.
- R2: The offset is bits [21:15] as a signed 7-bit value, sign-extended and multiplied by 16.
- R3: The access address is base+offset for mode 011 (pre-index) and mode 010 (plain offset). For mode 001 (post-index) it is the unmodified base.
- R4: Modes 001 and 011 write base+offset back to the base register after the tag write is accepted. Mode 010 performs no writeback.
- R5: For a general-register base, an access address with bits [3:0] not all zero gives fault_kind=1, with no write request and no writeback.
- R6: The requests go out in a fixed order. The first has mem_req_is_tag=0 and carries the register selected by bits [4:0] at the access address. The second has mem_req_is_tag=0 and carries the register selected by bits [14:10] at the access address+8. The third has mem_req_is_tag=1 and is sent to the access address with bits [3:0] cleared.
- R7: A base field (bits [9:5]) of 31 selects sp_rd_data. If its bits [3:0] are not zero, the unit faults with fault_kind=2, with no write and no writeback. Writeback for that base goes to sp_wr_en/sp_wr_data and never to rf_wr_en.
- R8: A data register field of 31 supplies the value zero, whatever the register file returns for index 31.
- R9: While mem_req_valid is high and mem_req_ready is low, the request stays valid with unchanged address, data and kind.
- R10: done or fault is a single-cycle pulse that ends each operation. busy is high from the cycle after start until that pulse. start is ignored while busy.
- R11: The tag request data is address bits [59:56] in data bits [3:0], with all other data bits zero. It is independent of the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| insn | input | 32 | Instruction word, latched with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fault | output | 1 | One-cycle pulse on a fault |
| fault_kind | output | 2 | 0 none, 1 granule misaligned, 2 stack pointer misaligned, 3 illegal encoding |
| rf_rn_idx | output | 5 | Read index for the base register |
| rf_rn_data | input | 64 | Base register value |
| rf_rt_idx | output | 5 | Read index for the first data register |
| rf_rt_data | input | 64 | First data register value |
| rf_rt2_idx | output | 5 | Read index for the second data register |
| rf_rt2_data | input | 64 | Second data register value |
| sp_rd_data | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_ready | input | 1 | Write request accepted |
| mem_req_is_tag | output | 1 | 1 for the tag write, 0 for a data write |
| mem_req_addr | output | 64 | Byte address of the write |
| mem_req_data | output | 64 | Data word, or tag in bits [3:0] |
| rf_wr_en | output | 1 | General register writeback strobe |
| rf_wr_idx | output | 5 | General register writeback index |
| rf_wr_data | output | 64 | General register writeback value |
| sp_wr_en | output | 1 | Stack pointer writeback strobe |
| sp_wr_data | output | 64 | Stack pointer writeback value |

## Verification
The bench uses extreme offsets in both signs (-1, +63, -64), because a design that zero-extends or forgets the ×16 scaling would send requests to wrong addresses and write back wrong bases. It runs post-index with a misaligned-looking offset and pre-index from an aligned stack pointer. A unit that used base+offset as the post-index access address, or wrote the stack pointer into register 31, would show wrong request addresses or a missing sp_wr_en. Misaligned bases, a misaligned stack pointer and several illegal encodings must produce the right fault kind with zero requests; a design that checks too late would leak a data write. Random ready stalls, zero-register data operands, tags that differ from the data's low nibble, and a start pulse mid-operation expose a unit that changes its payload under stall, reads register 31 literally, takes the tag from data, or restarts while busy.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int IDX_W = 5;
    localparam int IMM_W = 7;
    localparam logic [IDX_W-1:0] SP_IDX = 5'd31;

    localparam logic [2:0] MODE_POST = 3'b001;
    localparam logic [2:0] MODE_OFFS = 3'b010;
    localparam logic [2:0] MODE_PRE  = 3'b011;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_ALIGN    = 2'd1,
        FLT_SP_ALIGN = 2'd2,
        FLT_ILLEGAL  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_D1,
        ST_WR_D2,
        ST_WR_TAG,
        ST_WBACK,
        ST_DONE,
        ST_FAULT
    } state_e;

    typedef enum logic [1:0] {
        STEP_D1,
        STEP_D2,
        STEP_TAG
    } step_e;

    typedef struct packed {
        logic             legal;
        logic             wback;
        logic             postidx;
        logic [IMM_W-1:0] imm;
        logic [IDX_W-1:0] rt2;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rt;
    } dec_t;

endpackage

// File: rtl/tps_decoder.sv
module tps_decoder
    import tps_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic [2:0] mode;
    logic       opcode_hit;
    logic       mode_hit;

    always_comb begin
        mode       = insn[25:23];
        // R1: fixed opcode bits
        opcode_hit = (insn[31:30] == 2'b01) && (insn[29:27] == 3'b101)
                     && !insn[26] && !insn[22];
        mode_hit   = (mode == MODE_POST) || (mode == MODE_OFFS) || (mode == MODE_PRE);

        dec.legal   = opcode_hit && mode_hit;
        dec.wback   = (mode == MODE_POST) || (mode == MODE_PRE);
        dec.postidx = (mode == MODE_POST);
        dec.imm     = insn[21:15];
        dec.rt2     = insn[14:10];
        dec.rn      = insn[9:5];
        dec.rt      = insn[4:0];
    end
endmodule

// File: rtl/tps_agen.sv
module tps_agen #(
    parameter int XLEN    = 64,
    parameter int GRAN_LG = 4,
    parameter int IMM_W   = 7
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  logic             postidx,
    input  logic             base_is_sp,
    output logic [XLEN-1:0]  acc_addr,
    output logic [XLEN-1:0]  wb_addr,
    output logic             acc_misaligned,
    output logic             sp_misaligned
);
    localparam int EXT_W = XLEN - IMM_W - GRAN_LG;

    logic [XLEN-1:0] offset;

    always_comb begin
        // R2: sign-extend and scale by the granule size
        offset         = {{EXT_W{imm[IMM_W-1]}}, imm, {GRAN_LG{1'b0}}};
        wb_addr        = base + offset;
        // R3: post-index accesses at the unmodified base
        acc_addr       = postidx ? base : wb_addr;
        acc_misaligned = |acc_addr[GRAN_LG-1:0];
        sp_misaligned  = base_is_sp && (|base[GRAN_LG-1:0]);
    end
endmodule

// File: rtl/tps_reqmux.sv
module tps_reqmux
    import tps_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int GRAN_LG = 4,
    parameter int TAG_LSB = 56,
    parameter int TAG_W   = 4
) (
    input  step_e           step,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [XLEN-1:0] data1,
    input  logic [XLEN-1:0] data2,
    output logic [XLEN-1:0] req_addr,
    output logic [XLEN-1:0] req_data,
    output logic            req_is_tag
);
    localparam int WORD_BYTES = XLEN / 8;

    logic [TAG_W-1:0] tag;
    logic [XLEN-1:0]  gran_addr;

    always_comb begin
        // R11: tag comes from the address itself
        tag       = acc_addr[TAG_LSB +: TAG_W];
        gran_addr = {acc_addr[XLEN-1:GRAN_LG], {GRAN_LG{1'b0}}};
        unique case (step)
            STEP_D1: begin
                req_addr   = acc_addr;
                req_data   = data1;
                req_is_tag = 1'b0;
            end
            STEP_D2: begin
                req_addr   = acc_addr + XLEN'(WORD_BYTES);
                req_data   = data2;
                req_is_tag = 1'b0;
            end
            STEP_TAG: begin
                req_addr   = gran_addr;
                req_data   = {{(XLEN-TAG_W){1'b0}}, tag};
                req_is_tag = 1'b1;
            end
            default: begin
                req_addr   = acc_addr;
                req_data   = data1;
                req_is_tag = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tagpair_store_unit.sv
module tagpair_store_unit
    import tps_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int GRAN_LG = 4,
    parameter int TAG_LSB = 56,
    parameter int TAG_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     insn,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_kind,
    output logic [4:0]      rf_rn_idx,
    input  logic [XLEN-1:0] rf_rn_data,
    output logic [4:0]      rf_rt_idx,
    input  logic [XLEN-1:0] rf_rt_data,
    output logic [4:0]      rf_rt2_idx,
    input  logic [XLEN-1:0] rf_rt2_data,
    input  logic [XLEN-1:0] sp_rd_data,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_is_tag,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_data,
    output logic            rf_wr_en,
    output logic [4:0]      rf_wr_idx,
    output logic [XLEN-1:0] rf_wr_data,
    output logic            sp_wr_en,
    output logic [XLEN-1:0] sp_wr_data
);
    state_e          state_q, state_d;
    logic [31:0]     insn_q;
    dec_t            dec;
    logic            base_is_sp;
    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] acc_d, wb_d;
    logic            mis_d, spmis_d;
    fault_e          flt_d, flt_q;
    logic [XLEN-1:0] acc_q, wb_q, d1_q, d2_q;
    logic            wback_q, rn_sp_q;
    logic [4:0]      rn_q;
    step_e           step;

    tps_decoder u_dec (
        .insn (insn_q),
        .dec  (dec)
    );

    assign rf_rn_idx  = dec.rn;
    assign rf_rt_idx  = dec.rt;
    assign rf_rt2_idx = dec.rt2;
    // R7: base field 31 selects the stack pointer
    assign base_is_sp = (dec.rn == SP_IDX);
    assign base_val   = base_is_sp ? sp_rd_data : rf_rn_data;

    tps_agen #(
        .XLEN    (XLEN),
        .GRAN_LG (GRAN_LG),
        .IMM_W   (IMM_W)
    ) u_agen (
        .base           (base_val),
        .imm            (dec.imm),
        .postidx        (dec.postidx),
        .base_is_sp     (base_is_sp),
        .acc_addr       (acc_d),
        .wb_addr        (wb_d),
        .acc_misaligned (mis_d),
        .sp_misaligned  (spmis_d)
    );

    // fault priority: illegal, then stack pointer, then granule
    always_comb begin
        if (!dec.legal)   flt_d = FLT_ILLEGAL;
        else if (spmis_d) flt_d = FLT_SP_ALIGN;
        else if (mis_d)   flt_d = FLT_ALIGN;
        else              flt_d = FLT_NONE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_READ;
            ST_READ:   state_d = (flt_d != FLT_NONE) ? ST_FAULT : ST_WR_D1;
            ST_WR_D1:  if (mem_req_ready) state_d = ST_WR_D2;
            ST_WR_D2:  if (mem_req_ready) state_d = ST_WR_TAG;
            ST_WR_TAG: if (mem_req_ready) state_d = wback_q ? ST_WBACK : ST_DONE;
            ST_WBACK:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q  <= '0;
            acc_q   <= '0;
            wb_q    <= '0;
            d1_q    <= '0;
            d2_q    <= '0;
            wback_q <= 1'b0;
            rn_sp_q <= 1'b0;
            rn_q    <= '0;
            flt_q   <= FLT_NONE;
        end else begin
            if (state_q == ST_IDLE && start) insn_q <= insn;
            if (state_q == ST_READ) begin
                acc_q   <= acc_d;
                wb_q    <= wb_d;
                // R8: data field 31 reads as zero
                d1_q    <= (dec.rt  == SP_IDX) ? '0 : rf_rt_data;
                d2_q    <= (dec.rt2 == SP_IDX) ? '0 : rf_rt2_data;
                wback_q <= dec.wback;
                rn_sp_q <= base_is_sp;
                rn_q    <= dec.rn;
                flt_q   <= flt_d;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WR_D2:  step = STEP_D2;
            ST_WR_TAG: step = STEP_TAG;
            default:   step = STEP_D1;
        endcase
    end

    tps_reqmux #(
        .XLEN    (XLEN),
        .GRAN_LG (GRAN_LG),
        .TAG_LSB (TAG_LSB),
        .TAG_W   (TAG_W)
    ) u_req (
        .step       (step),
        .acc_addr   (acc_q),
        .data1      (d1_q),
        .data2      (d2_q),
        .req_addr   (mem_req_addr),
        .req_data   (mem_req_data),
        .req_is_tag (mem_req_is_tag)
    );

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_WR_D1) || (state_q == ST_WR_D2) || (state_q == ST_WR_TAG);
        done          = (state_q == ST_DONE);
        fault         = (state_q == ST_FAULT);
        fault_kind    = (state_q == ST_FAULT) ? flt_q : FLT_NONE;
        rf_wr_en      = (state_q == ST_WBACK) && !rn_sp_q;
        sp_wr_en      = (state_q == ST_WBACK) && rn_sp_q;
        rf_wr_idx     = rn_q;
        rf_wr_data    = wb_q;
        sp_wr_data    = wb_q;
    end

    // R9: payload holds under back-pressure
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_data) && $stable(mem_req_is_tag)));

    // R5: a fault is never preceded by a write request
    p_fault_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(mem_req_valid));

    // R5: every data request is word aligned
    p_data_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_is_tag) |-> (mem_req_addr[2:0] == 3'b000));

    // R6: the tag request follows an accepted data request
    p_tag_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid && mem_req_is_tag) |->
            $past(mem_req_valid && mem_req_ready && !mem_req_is_tag));

    // R4: writeback only right after the tag write is accepted
    p_wb_after_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || sp_wr_en) |-> $past(mem_req_valid && mem_req_ready && mem_req_is_tag));

    // R10: completion pulses are single-cycle and exclusive
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));
    p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R7: register and stack writebacks never coincide
    p_wb_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && sp_wr_en));
endmodule

// File: tb/test_tagpair_store_unit.sv
`timescale 1ns/1ps
module test_tagpair_store_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_kind;
    logic [4:0]  rf_rn_idx, rf_rt_idx, rf_rt2_idx, rf_wr_idx;
    logic [63:0] rf_rn_data, rf_rt_data, rf_rt2_data, sp_rd_data;
    logic        mem_req_valid, mem_req_ready, mem_req_is_tag;
    logic [63:0] mem_req_addr, mem_req_data;
    logic        rf_wr_en, sp_wr_en;
    logic [63:0] rf_wr_data, sp_wr_data;

    logic [63:0] rf [32];
    logic [63:0] sp_r;

    assign rf_rn_data  = rf[rf_rn_idx];
    assign rf_rt_data  = rf[rf_rt_idx];
    assign rf_rt2_data = rf[rf_rt2_idx];
    assign sp_rd_data  = sp_r;

    always #2.5 clk = ~clk;

    tagpair_store_unit i_tagpair_store_unit (.*);

    int nchk = 0;
    int nfail = 0;
    int nreq, nwb;
    logic [63:0] la [8];
    logic [63:0] ld [8];
    logic        lt [8];

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // behavioural memory / register file side
    always @(negedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (nreq < 8) begin
                la[nreq] = mem_req_addr;
                ld[nreq] = mem_req_data;
                lt[nreq] = mem_req_is_tag;
            end
            nreq++;
        end
        if (rst_n && rf_wr_en) begin rf[rf_wr_idx] = rf_wr_data; nwb++; end
        if (rst_n && sp_wr_en) begin sp_r = sp_wr_data; nwb++; end
    end

    initial begin
        mem_req_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            mem_req_ready = ($urandom_range(0, 3) != 0);
        end
    end

    function automatic logic [31:0] mk(input logic [2:0] mode, input logic [6:0] imm,
                                       input logic [4:0] rt2, input logic [4:0] rn, input logic [4:0] rt);
        return {2'b01, 3'b101, 1'b0, mode, 1'b0, imm, rt2, rn, rt};
    endfunction

    function automatic logic [63:0] scaled(input logic [6:0] imm);
        return {{53{imm[6]}}, imm, 4'b0000};
    endfunction

    function automatic bit is_legal(input logic [31:0] w);
        return (w[31:30] == 2'b01) && (w[29:27] == 3'b101) && !w[26] && !w[22]
               && (w[25:23] == 3'b001 || w[25:23] == 3'b010 || w[25:23] == 3'b011);
    endfunction

    task automatic run_op(input logic [31:0] w, input bit poke);
        logic [4:0]  rn, rt, rt2;
        logic [2:0]  mode;
        logic [63:0] base, d1, d2, newa, acc, got_base;
        logic [1:0]  eflt, gflt;
        bit          seen;
        int          cyc;
        rn = w[9:5]; rt = w[4:0]; rt2 = w[14:10]; mode = w[25:23];
        base = (rn == 5'd31) ? sp_r : rf[rn];
        d1   = (rt  == 5'd31) ? 64'd0 : rf[rt];
        d2   = (rt2 == 5'd31) ? 64'd0 : rf[rt2];
        newa = base + scaled(w[21:15]);
        acc  = (mode == 3'b001) ? base : newa;
        if (!is_legal(w))                         eflt = 2'd3;
        else if (rn == 5'd31 && base[3:0] != 0)   eflt = 2'd2;
        else if (acc[3:0] != 0)                   eflt = 2'd1;
        else                                      eflt = 2'd0;

        nreq = 0; nwb = 0;
        @(posedge clk); #1;
        start = 1'b1; insn = w;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", {63'd0, busy}, 64'd1);
        if (poke) begin
            start = 1'b1; insn = mk(3'b010, 7'd1, 5'd2, 5'd3, 5'd4);
            @(negedge clk);
            start = 1'b0;
        end
        seen = 0; gflt = 0; cyc = 0;
        while (!seen && cyc < 300) begin
            if (done || fault) begin
                seen = 1;
                gflt = fault ? fault_kind : 2'd0;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(seen, "R10 operation ended by pulse", {63'd0, seen}, 64'd1);
        chk(gflt == eflt, "R1 R5 R7 fault kind", {62'd0, gflt}, {62'd0, eflt});
        if (eflt != 0) begin
            chk(nreq == 0 && nwb == 0, "R5 no writes on fault", 64'(nreq + nwb), 64'd0);
        end else begin
            chk(nreq == 3, "R6 request count", 64'(nreq), 64'd3);
            chk(la[0] == acc && !lt[0], "R3 R2 first address", la[0], acc);
            chk(ld[0] == d1, "R6 R8 R9 first data", ld[0], d1);
            chk(la[1] == acc + 64'd8 && !lt[1], "R6 second address", la[1], acc + 64'd8);
            chk(ld[1] == d2, "R6 R8 R9 second data", ld[1], d2);
            chk(la[2] == {acc[63:4], 4'b0000} && lt[2], "R6 tag address", la[2], acc);
            chk(ld[2] == {60'd0, acc[59:56]}, "R11 tag value", ld[2], {60'd0, acc[59:56]});
            if (mode == 3'b010) begin
                chk(nwb == 0, "R4 no writeback in offset mode", 64'(nwb), 64'd0);
            end else begin
                got_base = (rn == 5'd31) ? sp_r : rf[rn];
                chk(nwb == 1, "R4 one writeback", 64'(nwb), 64'd1);
                chk(got_base == newa, "R2 R4 R7 written base", got_base, newa);
            end
        end
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle after pulse", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        #750000;
        nfail++;
        $display("FAIL R10 watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
        sp_r = 64'h0000_7FFF_0000_1000;
        nreq = 0; nwb = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req_valid && !rf_wr_en && !sp_wr_en,
            "R10 reset state", {60'd0, busy, done, fault, mem_req_valid}, 64'd0);

        // R2 R3: pre-index, offset -1 granule
        rf[1] = 64'h0A00_0000_0000_0100;
        run_op(mk(3'b011, 7'h7F, 5'd4, 5'd1, 5'd3), 0);
        // R3 R4: post-index, largest positive offset
        rf[1] = 64'h0300_0000_0000_2000;
        run_op(mk(3'b001, 7'h3F, 5'd4, 5'd1, 5'd3), 0);
        // R4: plain offset, most negative offset, no writeback
        rf[2] = 64'h0000_0000_0001_0000;
        run_op(mk(3'b010, 7'h40, 5'd5, 5'd2, 5'd6), 0);
        // R5: misaligned general base
        rf[7] = 64'h0000_0000_0000_1008;
        run_op(mk(3'b010, 7'd2, 5'd5, 5'd7, 5'd6), 0);
        // R7: misaligned stack pointer, then aligned pre-index on stack pointer
        sp_r = 64'h0000_0000_0000_4004;
        run_op(mk(3'b011, 7'd1, 5'd5, 5'd31, 5'd6), 0);
        sp_r = 64'h0500_0000_0000_4000;
        run_op(mk(3'b011, 7'h7E, 5'd5, 5'd31, 5'd6), 0);
        run_op(mk(3'b001, 7'd3, 5'd5, 5'd31, 5'd6), 0);
        // R1: illegal encodings
        run_op(mk(3'b000, 7'd0, 5'd1, 5'd2, 5'd3), 0);
        run_op(mk(3'b111, 7'd0, 5'd1, 5'd2, 5'd3), 0);
        run_op(mk(3'b010, 7'd0, 5'd1, 5'd2, 5'd3) | 32'h0040_0000, 0);
        run_op(mk(3'b010, 7'd0, 5'd1, 5'd2, 5'd3) | 32'h0400_0000, 0);
        run_op(mk(3'b010, 7'd0, 5'd1, 5'd2, 5'd3) ^ 32'h8000_0000, 0);
        // R8: both data fields select the zero register
        rf[31] = 64'hDEAD_BEEF_CAFE_F00D;
        rf[9]  = 64'h0000_0000_0000_0300;
        run_op(mk(3'b010, 7'd1, 5'd31, 5'd9, 5'd31), 0);
        // R11: tag from address, data low nibble differs
        rf[10] = 64'h0A00_0000_0000_0800;
        rf[11] = 64'h0000_0000_0000_0005;
        run_op(mk(3'b010, 7'd0, 5'd12, 5'd10, 5'd11), 0);
        // R10: start pulse while busy is ignored
        rf[1] = 64'h0000_0000_0000_6000;
        run_op(mk(3'b011, 7'd2, 5'd4, 5'd1, 5'd3), 1);

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [2:0]  m;
            logic [4:0]  rn;
            logic [63:0] b;
            logic [31:0] w;
            int sel;
            sel = $urandom_range(0, 19);
            m  = (sel < 7) ? 3'b001 : (sel < 13) ? 3'b010 : (sel < 19) ? 3'b011 : 3'($urandom_range(0, 7));
            rn = 5'($urandom_range(0, 31));
            b  = {$urandom, $urandom};
            if ($urandom_range(0, 6) != 0) b[3:0] = 4'h0;
            if (rn == 5'd31) sp_r = b; else rf[rn] = b;
            for (int j = 0; j < 31; j++) if (5'(j) != rn && $urandom_range(0, 3) == 0) rf[j] = {$urandom, $urandom};
            w = mk(m, 7'($urandom), 5'($urandom), rn, 5'($urandom));
            run_op(w, 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule